// File: doc/BRIEF.md
# Queued-Frame Serial Transmitter

This block is the transmit half of an asynchronous serial port. A one-cycle bit-rate pulse from an external divider paces the line. Software places a byte in a holding register. When the shifter reaches a frame boundary, the byte moves into the shifter and goes out as a start bit, eight data bits with the least significant bit first, and a stop bit. Two flags report progress. One shows that the holding register is free again. The other shows that the line has gone quiet with nothing left to send. Each flag can raise a shared interrupt request.

Besides data, the shifter can send two special frames: a run of ten idle marks (a preamble) and a break word. Software asks for them with its enable and break controls. A preamble or break that is asked for while a frame is on the line waits in a flag and is sent at the next frame boundary. The frame in flight is never cut short. The block also drives an output enable, which tells the pad logic whether the serial pin belongs to the port or to general-purpose use.

Top module: `uart_tx_queued`

## Requirements
- R1: `ser_out` idles at 1. A data frame is one 0 bit, then `wr_data[0]` to `wr_data[7]`, then one 1 bit. Each bit is held from one `bit_tick` edge to the next.
- R2: A write (`wr_valid`=1) while `dre`=1 stores the byte and clears `dre`. A write while `dre`=0 is ignored. `dre` returns to 1 on the clock edge where the byte enters the shifter.
- R3: `tc` is 1 after reset. It clears on an accepted write and whenever any frame starts. It sets on the tick that ends a frame when no new frame starts on that tick.
- R4: `irq` equals (`dre_ie` AND `dre`) OR (`tc_ie` AND `tc`).
- R5: When `tx_en` rises while the shifter is idle, the next `bit_tick` starts nothing. The earliest frame start is on the tick after it, which gives a delay of one bit time.
- R6: If `tx_en` goes from 0 to 1 while a frame is being sent, one preamble of ten 1 bits is queued. It is sent after the current frame.
- R7: A 1-to-0 change on `brk_ctl` queues one break word: ten 0 bits followed by one 1 bit. It is sent after the frame that is currently on the line.
- R8: While `brk_ctl` is 1, every frame boundary at which a frame may start begins a break word.
- R9: When several frames are waiting at a boundary, the one sent is chosen in this order: queued preamble, queued break, held break, holding-register byte.
- R10: Frames start only at a tick boundary, and only while `tx_en` has been 1 for at least one cycle. If `tx_en` is low, the current frame finishes, nothing new starts, and waiting requests are kept.
- R11: `pin_oe` is 1 while `tx_en` is 1. It is also 1 while `rx_en` is 1, provided `tx_en` has been 1 at some time since reset. Otherwise it is 0.
- R12: After reset, `ser_out`=1, `dre`=1, `tc`=1 and `pin_oe`=0, and no frame is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable (used only for pin ownership) |
| brk_ctl | input | 1 | Send-break control |
| dre_ie | input | 1 | Interrupt enable for `dre` |
| tc_ie | input | 1 | Interrupt enable for `tc` |
| wr_valid | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| ser_out | output | 1 | Serial line |
| pin_oe | output | 1 | Serial pin owned by the port |
| dre | output | 1 | Holding register empty |
| tc | output | 1 | Transmission complete |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `bit_tick` is a single-cycle pulse, and that the control inputs are stable for a whole clock cycle so that their edges are seen exactly once. They also assume that writes arrive as one-cycle strobes. The stimulus changes every input only on the falling clock edge. It produces the tick from a fixed four-cycle count, and it drives each write and each control toggle as a discrete event. This keeps every edge that the properties watch unambiguous.

// File: rtl/uatx_pkg.sv
package uatx_pkg;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_PRE  = 2'd1,
        LD_BRK  = 2'd2,
        LD_DATA = 2'd3
    } ld_kind_e;

    typedef struct packed {
        logic te;      // tx enable seen last cycle
        logic brk;     // break control seen last cycle
        logic dly;     // one-bit start delay pending
        logic ppre;    // preamble waiting
        logic pbrk;    // break word waiting
        logic seen;    // transmitter enabled at least once
    } sched_st_t;

endpackage

// File: rtl/uatx_sched.sv
module uatx_sched
    import uatx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     bit_tick,
    input  logic     tx_en,
    input  logic     rx_en,
    input  logic     brk_ctl,
    input  logic     boundary,
    input  logic     busy,
    input  logic     hold_empty,
    output ld_kind_e ld_kind,
    output logic     pin_oe
);

    sched_st_t s_d, s_q;
    ld_kind_e  ld_d;

    always_comb begin
        s_d  = s_q;
        ld_d = LD_NONE;
        if (bit_tick && s_q.dly) begin
            s_d.dly = 1'b0;
        end
        if (boundary && tx_en && s_q.te && !s_q.dly) begin
            if (s_q.ppre) begin
                ld_d     = LD_PRE;
                s_d.ppre = 1'b0;
            end else if (s_q.pbrk) begin
                ld_d     = LD_BRK;
                s_d.pbrk = 1'b0;
            end else if (brk_ctl) begin
                ld_d = LD_BRK;
            end else if (!hold_empty) begin
                ld_d = LD_DATA;
            end
        end
        if (tx_en && !s_q.te) begin
            if (busy) s_d.ppre = 1'b1;
            else      s_d.dly  = 1'b1;
        end
        if (s_q.brk && !brk_ctl) begin
            s_d.pbrk = 1'b1;
        end
        s_d.te   = tx_en;
        s_d.brk  = brk_ctl;
        s_d.seen = s_q.seen | tx_en;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ld_kind = ld_d;
    assign pin_oe  = tx_en | (s_q.seen & rx_en);

endmodule

// File: rtl/uatx_shifter.sv
module uatx_shifter
    import uatx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  ld_kind_e          ld_kind,
    input  logic [DATA_W-1:0] hold,
    output logic              ser_out,
    output logic              busy,
    output logic              boundary,
    output logic              done_idle
);

    localparam int FRM_LEN = DATA_W + 2;
    localparam int BRK_LEN = DATA_W + 3;
    localparam int CNT_W   = $clog2(BRK_LEN + 1);

    typedef struct packed {
        logic [BRK_LEN-1:0] frame;
        logic [CNT_W-1:0]   left;
    } shift_st_t;

    shift_st_t s_d, s_q;
    logic      last_bit;

    assign busy     = (s_q.left != '0);
    assign last_bit = (s_q.left == CNT_W'(1));
    assign boundary = bit_tick && (!busy || last_bit);

    always_comb begin
        s_d = s_q;
        if (bit_tick && busy) begin
            s_d.frame = {1'b1, s_q.frame[BRK_LEN-1:1]};
            s_d.left  = s_q.left - CNT_W'(1);
        end
        unique case (ld_kind)
            LD_PRE: begin
                s_d.frame = '1;
                s_d.left  = CNT_W'(FRM_LEN);
            end
            LD_BRK: begin
                s_d.frame = {1'b1, {(BRK_LEN-1){1'b0}}};
                s_d.left  = CNT_W'(BRK_LEN);
            end
            LD_DATA: begin
                s_d.frame = {2'b11, hold, 1'b0};
                s_d.left  = CNT_W'(FRM_LEN);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ser_out   = busy ? s_q.frame[0] : 1'b1;
    assign done_idle = bit_tick && last_bit && (ld_kind == LD_NONE);

endmodule

// File: rtl/uatx_holding.sv
module uatx_holding
    import uatx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  ld_kind_e          ld_kind,
    input  logic              done_idle,
    output logic [DATA_W-1:0] hold,
    output logic              dre,
    output logic              tc
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              empty;
        logic              done;
    } hold_st_t;

    hold_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (ld_kind == LD_DATA) begin
            s_d.empty = 1'b1;
        end
        if (ld_kind != LD_NONE) begin
            s_d.done = 1'b0;
        end else if (done_idle) begin
            s_d.done = 1'b1;
        end
        if (wr_valid && s_q.empty) begin
            s_d.data  = wr_data;
            s_d.empty = 1'b0;
            s_d.done  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.data  <= '0;
            s_q.empty <= 1'b1;
            s_q.done  <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign hold = s_q.data;
    assign dre  = s_q.empty;
    assign tc   = s_q.done;

endmodule

// File: rtl/uart_tx_queued.sv
module uart_tx_queued
    import uatx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              brk_ctl,
    input  logic              dre_ie,
    input  logic              tc_ie,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ser_out,
    output logic              pin_oe,
    output logic              dre,
    output logic              tc,
    output logic              irq
);

    ld_kind_e          ld_kind;
    logic              busy;
    logic              boundary;
    logic              done_idle;
    logic [DATA_W-1:0] hold;

    uatx_sched u_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_tick   (bit_tick),
        .tx_en      (tx_en),
        .rx_en      (rx_en),
        .brk_ctl    (brk_ctl),
        .boundary   (boundary),
        .busy       (busy),
        .hold_empty (dre),
        .ld_kind    (ld_kind),
        .pin_oe     (pin_oe)
    );

    uatx_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .ld_kind   (ld_kind),
        .hold      (hold),
        .ser_out   (ser_out),
        .busy      (busy),
        .boundary  (boundary),
        .done_idle (done_idle)
    );

    uatx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_data   (wr_data),
        .ld_kind   (ld_kind),
        .done_idle (done_idle),
        .hold      (hold),
        .dre       (dre),
        .tc        (tc)
    );

    assign irq = (dre_ie & dre) | (tc_ie & tc);

endmodule

// File: rtl/uatx_check.sv
module uatx_check
    import uatx_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     tx_en,
    input logic     rx_en,
    input logic     dre_ie,
    input logic     tc_ie,
    input logic     wr_valid,
    input logic     ser_out,
    input logic     pin_oe,
    input logic     dre,
    input logic     tc,
    input logic     irq,
    input logic     busy,
    input ld_kind_e ld_kind
);

    p_dre_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dre_ie && dre) |-> irq);

    p_tc_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_ie && tc) |-> irq);

    p_pin_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !rx_en) |-> !pin_oe);

    p_load_frees_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_kind == LD_DATA) |=> dre);

    p_write_clears_tc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && dre) |=> !tc);

    p_start_bit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_kind == LD_DATA) |=> !ser_out);

    p_enable_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_en) && !busy) |=> (ser_out && !busy));

    p_preamble_mark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_kind == LD_PRE) |=> ser_out);

    p_break_space_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_kind == LD_BRK) |=> !ser_out);

    p_idle_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !busy) |=> !busy);

endmodule

bind uart_tx_queued uatx_check u_check (
    .clk      (clk),
    .rst_n    (rst_n),
    .tx_en    (tx_en),
    .rx_en    (rx_en),
    .dre_ie   (dre_ie),
    .tc_ie    (tc_ie),
    .wr_valid (wr_valid),
    .ser_out  (ser_out),
    .pin_oe   (pin_oe),
    .dre      (dre),
    .tc       (tc),
    .irq      (irq),
    .busy     (busy),
    .ld_kind  (ld_kind)
);

// File: tb/uart_tx_queued_test.sv
`timescale 1ns/1ps
module uart_tx_queued_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_tick = 1'b0;
    logic       tx_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       brk_ctl = 1'b0;
    logic       dre_ie = 1'b0;
    logic       tc_ie = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ser_out, pin_oe, dre, tc, irq;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    int    wd = 0;
    string tag = "R1";
    bit    logging = 1'b0;
    int    line_log[$];

    always #4 clk = ~clk;  // 125 MHz

    uart_tx_queued uut (
        .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .tx_en(tx_en),
        .rx_en(rx_en), .brk_ctl(brk_ctl), .dre_ie(dre_ie), .tc_ie(tc_ie),
        .wr_valid(wr_valid), .wr_data(wr_data), .ser_out(ser_out),
        .pin_oe(pin_oe), .dre(dre), .tc(tc), .irq(irq)
    );

    // behavioural reference: a queue of line bits plus request flags
    int         m_line[$];
    bit         m_dre, m_tc, m_dly, m_ppre, m_pbrk, m_seen, m_te0, m_brk0;
    logic [7:0] m_hold;

    task automatic push_frame(input int kind, input logic [7:0] b);
        if (kind == 0) begin
            for (int i = 0; i < 10; i++) m_line.push_back(1);
        end else if (kind == 1) begin
            for (int i = 0; i < 10; i++) m_line.push_back(0);
            m_line.push_back(1);
        end else begin
            m_line.push_back(0);
            for (int i = 0; i < 8; i++) m_line.push_back(int'(b[i]));
            m_line.push_back(1);
        end
    endtask

    always @(posedge clk) begin : model
        bit busy0, dre0, dly0, loaded, ended;
        if (!rst_n) begin
            m_line.delete();
            m_dre = 1; m_tc = 1; m_dly = 0; m_ppre = 0; m_pbrk = 0;
            m_seen = 0; m_te0 = 0; m_brk0 = 0; m_hold = 8'h00;
        end else begin
            busy0 = (m_line.size() != 0);
            dre0 = m_dre; dly0 = m_dly; loaded = 0; ended = 0;
            if (bit_tick) begin
                if (m_line.size() != 0) begin
                    void'(m_line.pop_front());
                    if (m_line.size() == 0) ended = 1;
                end
                if (m_line.size() == 0 && tx_en && m_te0 && !dly0) begin
                    if (m_ppre) begin
                        m_ppre = 0; push_frame(0, 8'h00); loaded = 1;
                    end else if (m_pbrk) begin
                        m_pbrk = 0; push_frame(1, 8'h00); loaded = 1;
                    end else if (brk_ctl) begin
                        push_frame(1, 8'h00); loaded = 1;
                    end else if (!dre0) begin
                        push_frame(2, m_hold); m_dre = 1; loaded = 1;
                    end
                end
                if (dly0) m_dly = 0;
            end
            if (loaded) m_tc = 0;
            else if (ended) m_tc = 1;
            if (tx_en && !m_te0) begin
                if (busy0) m_ppre = 1;
                else       m_dly = 1;
            end
            if (m_brk0 && !brk_ctl) m_pbrk = 1;
            if (wr_valid && dre0) begin
                m_hold = wr_data; m_dre = 0; m_tc = 0;
            end
            m_seen = m_seen | tx_en;
            m_te0 = tx_en;
            m_brk0 = brk_ctl;
        end
    end

    task automatic chk(input logic act, input logic exp, input string what,
                       input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s at cycle %0d: actual=%b expected=%b",
                     req, what, cyc, act, exp);
        end
    endtask

    task automatic compare_all();
        logic e_txd, e_oe, e_irq;
        e_txd = (m_line.size() != 0) ? logic'(m_line[0][0]) : 1'b1;
        e_oe  = tx_en | (m_seen & rx_en);
        e_irq = (dre_ie & m_dre) | (tc_ie & m_tc);
        chk(ser_out, e_txd, "ser_out", tag);
        chk(dre, m_dre, "dre", "R2");
        chk(tc, m_tc, "tc", "R3");
        chk(irq, e_irq, "irq", "R4");
        chk(pin_oe, e_oe, "pin_oe", "R11");
    endtask

    task automatic step();
        @(negedge clk);
        if (rst_n) compare_all();
        cyc++;
        bit_tick = (cyc % 4 == 0);
        if (bit_tick && logging) line_log.push_back(int'(ser_out));
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic write_byte(input logic [7:0] b);
        wr_valid = 1'b1;
        wr_data = b;
        step();
        wr_valid = 1'b0;
    endtask

    function automatic int longest_zero_run();
        int best = 0;
        int run = 0;
        foreach (line_log[i]) begin
            if (line_log[i] == 0) begin
                run++;
                if (run > best) best = run;
            end else begin
                run = 0;
            end
        end
        return best;
    endfunction

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            bad++;
            total++;
            $display("FAIL R1 watchdog expired: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        steps(4);
        rst_n = 1'b1;
        step();
        // R12: reset state
        chk(ser_out, 1'b1, "reset ser_out", "R12");
        chk(dre, 1'b1, "reset dre", "R12");
        chk(tc, 1'b1, "reset tc", "R12");
        chk(pin_oe, 1'b0, "reset pin_oe", "R12");
        // R11: receiver alone does not claim the pin before any enable
        rx_en = 1'b1;
        step();
        chk(pin_oe, 1'b0, "rx only, never enabled", "R11");
        rx_en = 1'b0;

        // R5 / R1 / R2: enable, start delay, data frames
        tag = "R5";
        dre_ie = 1'b1; tc_ie = 1'b1;
        write_byte(8'hA5);
        chk(dre, 1'b0, "dre after write", "R2");
        tx_en = 1'b1;
        steps(20);
        tag = "R1";
        write_byte(8'h3C);
        write_byte(8'h77);  // ignored while full
        steps(120);
        chk(tc, 1'b1, "tc after line drains", "R3");

        // R6: enable toggle mid frame queues preamble ahead of data
        tag = "R6";
        write_byte(8'h5A);
        steps(14);
        tx_en = 1'b0;
        step();
        tx_en = 1'b1;
        write_byte(8'hC3);
        steps(140);

        // R7: break pulse mid frame queues one break word
        tag = "R7";
        line_log.delete();
        logging = 1'b1;
        write_byte(8'h81);
        steps(10);
        brk_ctl = 1'b1;
        step();
        brk_ctl = 1'b0;
        write_byte(8'hFF);
        steps(140);
        logging = 1'b0;
        total++;
        if (longest_zero_run() != 10) begin
            bad++;
            $display("FAIL R7 break length: actual=%0d expected=10",
                     longest_zero_run());
        end

        // R8: held break repeats break words
        tag = "R8";
        brk_ctl = 1'b1;
        steps(120);
        brk_ctl = 1'b0;
        steps(100);

        // R9: queued preamble and break both waiting with data held
        tag = "R9";
        write_byte(8'h12);
        steps(6);
        brk_ctl = 1'b1;
        step();
        brk_ctl = 1'b0;
        tx_en = 1'b0;
        step();
        tx_en = 1'b1;
        write_byte(8'h34);
        steps(200);

        // R10: disable mid frame; frame finishes, nothing new starts
        tag = "R10";
        write_byte(8'h6E);
        steps(10);
        tx_en = 1'b0;
        write_byte(8'h99);
        steps(120);
        chk(dre, 1'b0, "byte held while disabled", "R10");
        chk(ser_out, 1'b1, "line idle while disabled", "R10");

        // R11: pin ownership after enable has been seen
        rx_en = 1'b1;
        step();
        chk(pin_oe, 1'b1, "rx only after enable seen", "R11");
        rx_en = 1'b0;
        step();
        chk(pin_oe, 1'b0, "both enables clear", "R11");

        tag = "R5";
        tx_en = 1'b1;
        steps(120);
        chk(dre, 1'b1, "held byte sent after re-enable", "R10");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule